// File: doc/BRIEF.md
# Latched-Address Inverting Scratchpad RAM

This block is a small 16-word by 4-bit read/write store. Its control pins behave like those of an asynchronous static memory, but they are brought into a system clock domain. Two inputs drive it, both active low. One is a memory enable, which selects the block. The other is a write enable, which chooses between writing and reading. An internal register takes the word address at the moment the enable goes from high to low. After that moment the address pins may change freely until the enable is released.

A read returns the bitwise complement of the word stored at the captured address. A write stores the data inputs at the captured address. The output side consists of a data vector plus an output-enable flag. A wrapper further up the hierarchy can use the two to build a three-state driver. The flag is low, and the data vector is all zeros, whenever the block is writing or is not selected.

All four control and data inputs pass through a two-flop synchronizer before the logic uses them. Add two cycles of latency to every pin change for this reason.

Top module: `latch_inv_ram`

## Requirements
- R1: The store holds 16 independent 4-bit words. A word written at one address is read back unchanged after every other address has been written.
- R2: The word address is captured only when memory enable falls from 1 to 0. Address changes while the enable stays low do not change which word is read or written.
- R3: A block whose memory enable is already low at the end of reset stays unselected (dout_oe = 0) until the enable has gone high and then low again.
- R4: While selected with write enable low, the data inputs are stored at the captured address. Within one selection, a read, then a write, then a read returns the new word.
- R5: While selected with write enable high, dout_oe is 1 and dout equals the bitwise complement of the stored word. Repeated reads leave the word unchanged.
- R6: dout_oe is 0 while memory enable is high, and it is 0 while write enable is low.
- R7: When dout_oe is 0, dout is 4'b0000.
- R8: Synchronous reset deselects the block and clears the captured address, even if a read is in progress and the enable stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_en_n | input | 1 | Memory enable, active low; a falling edge selects the block and captures the address |
| wr_en_n | input | 1 | Write enable, active low |
| addr | input | 4 | Word address |
| din | input | 4 | Write data |
| dout | output | 4 | Inverted read data; zero when not driving |
| dout_oe | output | 1 | High when dout should be driven onto a shared bus |

## Verification
The assertions look at the synchronized control signals rather than the raw pins. They take it for granted that every pin holds steady for at least two clock cycles around each enable edge, so that address, data and control all reach the logic in the same cycle. The stimulus meets this by driving every pin on the falling clock edge and waiting several cycles after each change. It only moves the address or data once the captured values have settled. Nothing reads the store before a location has been written, because the array is not initialised.

// File: rtl/lair_pkg.sv
package lair_pkg;

    parameter int unsigned ADDR_W      = 4;
    parameter int unsigned DATA_W      = 4;
    parameter int unsigned SYNC_STAGES = 2;

    localparam int unsigned DEPTH = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    // Raw pin bundle carried through the synchronizer as one vector.
    typedef struct packed {
        logic  en_n;
        logic  we_n;
        addr_t addr;
        data_t data;
    } pin_bus_t;

    localparam int unsigned PIN_W = $bits(pin_bus_t);

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    function automatic data_t invert_word(input data_t w);
        return ~w;
    endfunction

    function automatic logic op_drives(input op_e op);
        return op == OP_READ;
    endfunction

endpackage

// File: rtl/lair_sync.sv
module lair_sync #(
    parameter int unsigned WIDTH   = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= RST_VAL;
                    else     stage_q[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= RST_VAL;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/lair_ctrl.sv
module lair_ctrl
    import lair_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_s,
    input  logic  we_s,
    input  addr_t addr_s,
    output logic  fall,
    output logic  sel_q,
    output addr_t addr_q,
    output op_e   op
);

    // Previous enable level. It resets to 0, the "enabled" level, so an
    // enable held low through reset produces no falling edge.
    logic en_prev_q;

    always_ff @(posedge clk) begin
        if (rst) en_prev_q <= 1'b0;
        else     en_prev_q <= en_s;
    end

    assign fall = en_prev_q & ~en_s;

    always_ff @(posedge clk) begin
        if (rst)       sel_q <= 1'b0;
        else if (en_s) sel_q <= 1'b0;
        else if (fall) sel_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)       addr_q <= '0;
        else if (fall) addr_q <= addr_s;
    end

    always_comb begin
        op = OP_IDLE;
        if (sel_q && !en_s) begin
            op = we_s ? OP_READ : OP_WRITE;
        end
    end

endmodule

// File: rtl/lair_array.sv
module lair_array #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 4
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int unsigned WORDS = 1 << AW;

    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/latch_inv_ram.sv
module latch_inv_ram
    import lair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_en_n,
    input  logic              wr_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    pin_bus_t pins_raw;
    pin_bus_t pins_s;

    assign pins_raw = '{en_n: mem_en_n, we_n: wr_en_n, addr: addr, data: din};

    lair_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL('0)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    logic  en_s;
    logic  we_s;
    logic  fall;
    logic  sel_q;
    addr_t addr_q;
    op_e   op;
    data_t rd_word;

    assign en_s = pins_s.en_n;
    assign we_s = pins_s.we_n;

    lair_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .en_s   (en_s),
        .we_s   (we_s),
        .addr_s (pins_s.addr),
        .fall   (fall),
        .sel_q  (sel_q),
        .addr_q (addr_q),
        .op     (op)
    );

    lair_array #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (op == OP_WRITE),
        .wr_addr (addr_q),
        .wr_data (pins_s.data),
        .rd_addr (addr_q),
        .rd_data (rd_word)
    );

    assign dout_oe = op_drives(op);
    assign dout    = dout_oe ? invert_word(rd_word) : '0;

endmodule

// File: rtl/lair_checker.sv
module lair_checker
    import lair_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  en_s,
    input logic  we_s,
    input logic  fall,
    input logic  sel_q,
    input addr_t addr_q,
    input data_t dout,
    input logic  dout_oe
);

    AST_OE_OFF_DISABLED: assert property (@(posedge clk) disable iff (rst)
        en_s |-> !dout_oe) else $error("oe while disabled"); // R6

    AST_OE_OFF_WRITING: assert property (@(posedge clk) disable iff (rst)
        !we_s |-> !dout_oe) else $error("oe while writing"); // R6

    AST_DOUT_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> (dout == '0)) else $error("dout not zero"); // R7

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(addr_q)) else $error("address moved without edge"); // R2

    AST_SEL_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!sel_q && !fall) |=> !sel_q) else $error("selected without edge"); // R3

    AST_READ_STEADY: assert property (@(posedge clk) disable iff (rst)
        (dout_oe && $past(dout_oe)) |-> $stable(dout)) else $error("read disturbed"); // R5

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (addr_q == '0 && !sel_q)) else $error("reset did not clear"); // R8

endmodule

bind latch_inv_ram lair_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_s    (en_s),
    .we_s    (we_s),
    .fall    (fall),
    .sel_q   (sel_q),
    .addr_q  (addr_q),
    .dout    (dout),
    .dout_oe (dout_oe)
);

// File: tb/latch_inv_ram_tb.sv
`timescale 1ns/1ps
module latch_inv_ram_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       mem_en_n;
    logic       wr_en_n;
    logic [3:0] addr;
    logic [3:0] din;
    logic [3:0] dout;
    logic       dout_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [3:0] ref_mem [16];

    always #2.5 clk = ~clk;

    latch_inv_ram u_dut (
        .clk      (clk),
        .rst      (rst),
        .mem_en_n (mem_en_n),
        .wr_en_n  (wr_en_n),
        .addr     (addr),
        .din      (din),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, {dout_oe, dout}, 5'h00);
    endtask

    task automatic write_word(input logic [3:0] a, input logic [3:0] d);
        mem_en_n = 1'b1; wr_en_n = 1'b1;
        step(4);
        addr = a; din = d;
        step(1);
        mem_en_n = 1'b0; wr_en_n = 1'b0;
        step(5);
        chk_idle("R6 write");
        mem_en_n = 1'b1; wr_en_n = 1'b1;
        step(5);
        chk_idle("R6 disabled");
        ref_mem[a] = d;
    endtask

    task automatic read_word(input logic [3:0] a, input string req);
        addr = a;
        step(1);
        mem_en_n = 1'b0; wr_en_n = 1'b1;
        step(5);
        chk(req, {dout_oe, dout}, {1'b1, ~ref_mem[a]});
        mem_en_n = 1'b1;
        step(5);
    endtask

    task automatic t_reset;
        rst = 1'b1; mem_en_n = 1'b1; wr_en_n = 1'b1; addr = '0; din = '0;
        step(3);
        rst = 1'b0;
        step(5);
        chk_idle("R8 reset state");
        chk_idle("R7 reset dout");
    endtask

    task automatic t_fill;
        for (int i = 0; i < 16; i++) write_word(4'(i), 4'((i * 7 + 3) & 15));
        for (int i = 0; i < 16; i++) read_word(4'(i), "R1 fill readback");
    endtask

    task automatic t_addr_hold;
        write_word(4'd3, 4'h6);
        write_word(4'd5, 4'h9);
        addr = 4'd3;
        step(1);
        mem_en_n = 1'b0; wr_en_n = 1'b1;
        step(5);
        addr = 4'd5;
        step(5);
        chk("R2 addr change ignored", {dout_oe, dout}, {1'b1, ~4'h6});
        mem_en_n = 1'b1;
        step(5);
    endtask

    task automatic t_no_edge_from_reset;
        rst = 1'b1; mem_en_n = 1'b0; wr_en_n = 1'b1; addr = 4'd3;
        step(3);
        rst = 1'b0;
        step(8);
        chk_idle("R3 no edge");
        mem_en_n = 1'b1;
        step(5);
        mem_en_n = 1'b0;
        step(5);
        chk("R3 after edge", {dout_oe, dout}, {1'b1, ~ref_mem[3]});
        mem_en_n = 1'b1;
        step(5);
    endtask

    task automatic t_read_write_read;
        addr = 4'd9;
        step(1);
        mem_en_n = 1'b0; wr_en_n = 1'b1;
        step(5);
        chk("R4 first read", {dout_oe, dout}, {1'b1, ~ref_mem[9]});
        addr = 4'd2; din = 4'hC;
        step(3);
        wr_en_n = 1'b0;
        step(5);
        chk_idle("R6 write in selection");
        wr_en_n = 1'b1;
        step(5);
        ref_mem[9] = 4'hC;
        chk("R4 new word", {dout_oe, dout}, {1'b1, ~4'hC});
        mem_en_n = 1'b1;
        step(5);
        read_word(4'd2, "R4 other addr untouched");
    endtask

    task automatic t_nondestructive;
        read_word(4'd7, "R5 read one");
        read_word(4'd7, "R5 read two");
        write_word(4'd0, 4'h0);
        read_word(4'd0, "R5 zero word");
        write_word(4'd15, 4'hF);
        read_word(4'd15, "R5 ones word");
    endtask

    task automatic t_reset_mid_read;
        addr = 4'd9;
        step(1);
        mem_en_n = 1'b0; wr_en_n = 1'b1;
        step(5);
        chk("R8 before reset", {dout_oe, dout}, {1'b1, ~ref_mem[9]});
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(6);
        chk_idle("R8 after reset");
        mem_en_n = 1'b1;
        step(5);
        read_word(4'd9, "R8 contents kept");
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset;
        t_fill;
        t_addr_hold;
        t_no_edge_from_reset;
        t_read_write_read;
        t_nondestructive;
        t_reset_mid_read;
        finish_run;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end

endmodule